// File: doc/BRIEF.md
# Performance Counter Access Front End

This block sits between the software-visible register access path and a bank of performance counters. It holds the stored value of every general-purpose and fixed counter. It shapes write data according to the path the write arrives on, and it answers reads made by register number or by a 32-bit counter-read index. It does no counting of its own; it only stores, shapes, selects and rejects.

A general-purpose counter can be written through two paths. The narrow path keeps the low 32 bits of the data and sign-extends bit 31. The wide path takes the data as it is and rejects it if any bit lies above the counter width. Fixed counters have a single path that trims the data to their width. Reads through any path return the stored value. The index path decodes a type flag and a fast flag from the top of the index. Every accepted request gets exactly one response on the following cycle. The response carries either data or a fault.

Top module: `pmc_access_front`

## Requirements
- R1: A write on the narrow general-purpose path (req_space = 0) stores data bits 31:0 with bit 31 copied into every bit from 32 up to GP_W-1, and bits at GP_W and above cleared.
- R2: A write on the wide general-purpose path (req_space = 1) whose data fits in GP_W bits stores the data unchanged and does not fault.
- R3: A wide-path write whose data has any bit set at position GP_W or above faults and leaves the counter unchanged.
- R4: Reading a general-purpose counter on the narrow path or on the wide path returns the same stored value, zero above GP_W.
- R5: A read on the index path (req_space = 3) selects a fixed counter when index bit 30 is 1 and a general-purpose counter when it is 0. Index bits 29:0 give the counter number.
- R6: An index-path read with index bit 31 set returns only bits 31:0 of the counter, with bits 63:32 zero.
- R7: A request that names a counter number at or beyond the number of counters of its type faults. This covers the index path (for example general-purpose index 64) and the direct paths.
- R8: A write on the fixed path (req_space = 2) to an existing fixed counter stores the data with bits at FIX_W and above cleared, and never faults.
- R9: A faulted request gives rsp_fault high together with rsp_valid for exactly that one response, and rsp_data is zero.
- R10: Each cycle with req_valid high produces rsp_valid high on the next cycle, and a cycle without a request produces none. Write responses carry zero data. After reset every counter reads zero.
- R11: A write on the index path faults and changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_space | input | 2 | 0 narrow GP path, 1 wide GP path, 2 fixed path, 3 read index |
| req_addr | input | 32 | Counter number, or the read index when req_space is 3 |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 1 | The request was rejected |
| rsp_data | output | 64 | Read data; zero for writes and faults |

## Verification
The bench instantiates the block with four general-purpose counters of 48 bits and three fixed counters of 40 bits. Because the two widths differ, a value written through the wrong mask or read from the wrong bank shows up in the data. The 48-bit width leaves room above bit 31, so sign extension, the fast-read truncation and the fault for over-wide data all produce distinct, visible results. With four and three counters, index 64, general-purpose 4 and fixed 3 all fall out of range and must fault.

// File: rtl/pmc_acc_pkg.sv
package pmc_acc_pkg;
  localparam int DATA_W   = 64;
  localparam int NARROW_W = 32;
  localparam int IDX_FAST  = 31;
  localparam int IDX_FIXED = 30;
  localparam int IDX_NUM_W = 30;

  typedef enum logic [1:0] {
    SP_NARROW = 2'd0,
    SP_WIDE   = 2'd1,
    SP_FIXED  = 2'd2,
    SP_INDEX  = 2'd3
  } acc_space_e;

  function automatic logic [DATA_W-1:0] width_mask(input int unsigned w);
    if (w >= DATA_W) return '1;
    return (64'd1 << w) - 64'd1;
  endfunction

  function automatic logic [DATA_W-1:0] narrow_shape(input logic [DATA_W-1:0] d,
                                                      input int unsigned w);
    logic [DATA_W-1:0] ext;
    ext = {{(DATA_W-NARROW_W){d[NARROW_W-1]}}, d[NARROW_W-1:0]};
    return ext & width_mask(w);
  endfunction

  function automatic logic exceeds_width(input logic [DATA_W-1:0] d,
                                         input int unsigned w);
    return (d & ~width_mask(w)) != '0;
  endfunction
endpackage

// File: rtl/pmc_wr_shaper.sv
module pmc_wr_shaper
  import pmc_acc_pkg::*;
#(
  parameter int GP_W  = 48,
  parameter int FIX_W = 40
) (
  input  acc_space_e        space,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] shaped,
  output logic              width_fault
);
  always_comb begin
    shaped      = '0;
    width_fault = 1'b0;
    unique case (space)
      SP_NARROW: shaped = narrow_shape(wdata, GP_W);
      SP_WIDE: begin
        shaped      = wdata & width_mask(GP_W);
        width_fault = exceeds_width(wdata, GP_W);
      end
      SP_FIXED:  shaped = wdata & width_mask(FIX_W);
      default:   shaped = '0;
    endcase
  end
endmodule

// File: rtl/pmc_idx_decoder.sv
module pmc_idx_decoder
  import pmc_acc_pkg::*;
#(
  parameter int NUM_GP  = 4,
  parameter int NUM_FIX = 3
) (
  input  logic [31:0]          index,
  output logic                 is_fixed,
  output logic                 is_fast,
  output logic [IDX_NUM_W-1:0] num,
  output logic                 range_fault
);
  localparam logic [IDX_NUM_W-1:0] GP_LIMIT  = IDX_NUM_W'(NUM_GP);
  localparam logic [IDX_NUM_W-1:0] FIX_LIMIT = IDX_NUM_W'(NUM_FIX);

  always_comb begin
    is_fixed    = index[IDX_FIXED];
    is_fast     = index[IDX_FAST];
    num         = index[IDX_NUM_W-1:0];
    range_fault = is_fixed ? (num >= FIX_LIMIT) : (num >= GP_LIMIT);
  end
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
  import pmc_acc_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [31:0]       rd_sel,
  output logic [DATA_W-1:0] rd_data
);
  logic [W-1:0] q [N];
  logic [N-1:0] hit;

  for (genvar i = 0; i < N; i++) begin : g_ctr
    assign hit[i] = wr_en && (wr_sel == 32'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)      q[i] <= '0;
      else if (hit[i]) q[i] <= wr_data[W-1:0];
    end

    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> q[i] == $past(wr_data[W-1:0]));
    p_hold_unwritten_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !hit[i] |=> $stable(q[i]));
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < N; k++)
      if (rd_sel == 32'(k)) rd_data = DATA_W'(q[k]);
  end

  p_one_target_r10: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit));
endmodule

// File: rtl/pmc_access_front.sv
module pmc_access_front
  import pmc_acc_pkg::*;
#(
  parameter int NUM_GP  = 4,
  parameter int NUM_FIX = 3,
  parameter int GP_W    = 48,
  parameter int FIX_W   = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [1:0]  req_space,
  input  logic [31:0] req_addr,
  input  logic [63:0] req_wdata,
  output logic        rsp_valid,
  output logic        rsp_fault,
  output logic [63:0] rsp_data
);
  localparam logic [31:0] GP_CNT  = 32'(NUM_GP);
  localparam logic [31:0] FIX_CNT = 32'(NUM_FIX);

  acc_space_e space;
  assign space = acc_space_e'(req_space);

  logic [DATA_W-1:0]    shaped;
  logic                 width_fault;
  logic                 idx_fixed, idx_fast, idx_range_fault;
  logic [IDX_NUM_W-1:0] idx_num;

  pmc_wr_shaper #(.GP_W(GP_W), .FIX_W(FIX_W)) u_shape (
    .space(space), .wdata(req_wdata), .shaped(shaped), .width_fault(width_fault));

  pmc_idx_decoder #(.NUM_GP(NUM_GP), .NUM_FIX(NUM_FIX)) u_idx (
    .index(req_addr), .is_fixed(idx_fixed), .is_fast(idx_fast),
    .num(idx_num), .range_fault(idx_range_fault));

  // Named request events
  logic is_index, tgt_fixed, fast_rd, addr_fault, acc_fault, gp_we, fix_we;
  logic [31:0] tgt_num;

  always_comb begin
    is_index  = (space == SP_INDEX);
    tgt_fixed = is_index ? idx_fixed : (space == SP_FIXED);
    tgt_num   = is_index ? 32'(idx_num) : req_addr;
    fast_rd   = is_index && idx_fast && !req_write;
    addr_fault = is_index ? (req_write || idx_range_fault)
                          : (tgt_fixed ? (req_addr >= FIX_CNT) : (req_addr >= GP_CNT));
    acc_fault = req_valid && (addr_fault ||
                (space == SP_WIDE && req_write && width_fault));
    gp_we  = req_valid && req_write && !acc_fault && !is_index && !tgt_fixed;
    fix_we = req_valid && req_write && !acc_fault && (space == SP_FIXED);
  end

  logic [DATA_W-1:0] gp_rd, fix_rd, sel_rd, rd_word;

  pmc_bank #(.N(NUM_GP), .W(GP_W)) u_gp (
    .clk(clk), .rst_n(rst_n), .wr_en(gp_we), .wr_sel(req_addr), .wr_data(shaped),
    .rd_sel(tgt_num), .rd_data(gp_rd));

  pmc_bank #(.N(NUM_FIX), .W(FIX_W)) u_fix (
    .clk(clk), .rst_n(rst_n), .wr_en(fix_we), .wr_sel(req_addr), .wr_data(shaped),
    .rd_sel(tgt_num), .rd_data(fix_rd));

  always_comb begin
    sel_rd  = tgt_fixed ? fix_rd : gp_rd;
    rd_word = fast_rd ? {{(DATA_W-NARROW_W){1'b0}}, sel_rd[NARROW_W-1:0]} : sel_rd;
    if (req_write || acc_fault) rd_word = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= acc_fault;
      rsp_data  <= req_valid ? rd_word : '0;
    end
  end

  p_rsp_follows_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_idle_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !rsp_fault);
  p_fault_zero_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_valid && rsp_data == '0);
  p_fast_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fast_rd && req_valid |=> rsp_data[DATA_W-1:NARROW_W] == '0);
  p_wide_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && space == SP_WIDE && width_fault |=> rsp_fault);
  p_index_write_reject_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && is_index |=> rsp_fault);
  p_gp_read_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && !tgt_fixed |=> (rsp_data & ~width_mask(GP_W)) == '0);
endmodule

// File: tb/pmc_access_front_tb.sv
module pmc_access_front_tb_top;
  localparam int NG = 4, NF = 3, GW = 48, FW = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_space = 2'd0;
  logic [31:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid, rsp_fault;
  logic [63:0] rsp_data;

  always #10 clk = ~clk;

  pmc_access_front #(.NUM_GP(NG), .NUM_FIX(NF), .GP_W(GW), .FIX_W(FW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_space(req_space), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_data(rsp_data));

  int tests = 0, fails = 0;
  bit done = 0;
  longint unsigned gp_m[NG];
  longint unsigned fx_m[NF];

  function automatic longint unsigned lim(int w);
    return (64'd1 << w) - 1;
  endfunction

  task automatic check(bit ok, string rq, longint unsigned act, longint unsigned exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // Behavioural reference: returns expected fault and data, updates model.
  task automatic model(int sp, bit wr, longint unsigned a, longint unsigned d,
                       output bit ef, output longint unsigned ed);
    longint unsigned v;
    longint unsigned n;
    ef = 0; ed = 0;
    if (sp == 3) begin
      n = a % (64'd1 << 30);
      if (wr) ef = 1;
      else if (a[30]) begin
        if (n >= NF) ef = 1; else ed = fx_m[n];
      end else begin
        if (n >= NG) ef = 1; else ed = gp_m[n];
      end
      if (!ef && a[31]) ed = ed % (64'd1 << 32);
    end else if (sp == 2) begin
      if (a >= NF) ef = 1;
      else if (wr) fx_m[a] = d & lim(FW);
      else ed = fx_m[a];
    end else begin
      if (a >= NG) ef = 1;
      else if (!wr) ed = gp_m[a];
      else if (sp == 0) begin
        v = d % (64'd1 << 32);
        if (v >= 64'h8000_0000) v = v + 64'hFFFF_FFFF_0000_0000;
        gp_m[a] = v & lim(GW);
      end else begin
        if (d > lim(GW)) ef = 1; else gp_m[a] = d;
      end
    end
  endtask

  task automatic req(int sp, bit wr, longint unsigned a, longint unsigned d, string rq);
    bit ef; longint unsigned ed;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_space = 2'(sp); req_addr = 32'(a); req_wdata = d;
    model(sp, wr, a, d, ef, ed);
    @(negedge clk);
    req_valid = 0;
    check(rsp_valid === 1'b1, "R10", 64'(rsp_valid), 1);
    check(rsp_fault === ef, rq, 64'(rsp_fault), 64'(ef));
    check(rsp_data === ed, rq, rsp_data, ed);
  endtask

  task automatic idle_check();
    @(negedge clk);
    check(rsp_valid === 1'b0 && rsp_fault === 1'b0, "R10", 64'(rsp_valid), 0);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    foreach (gp_m[i]) gp_m[i] = 0;
    foreach (fx_m[i]) fx_m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle_check();
    // R10 reset state through every path
    for (int i = 0; i < NG; i++) req(3, 0, i, 0, "R10");
    for (int i = 0; i < NF; i++) req(3, 0, 32'h4000_0000 | i, 0, "R10");
    // R1 narrow path, both signs of bit 31
    req(0, 1, 0, 64'hFFFF_FF01_2345_6789, "R1");
    req(1, 0, 0, 0, "R1");
    req(0, 1, 1, 64'h0000_0000_89AB_CDEF, "R1");
    req(0, 0, 1, 0, "R1");
    req(1, 0, 1, 0, "R4");
    // R2 wide path within width
    req(1, 1, 2, 64'h0000_FF01_2345_6789, "R2");
    req(0, 0, 2, 0, "R4");
    req(1, 0, 2, 0, "R4");
    req(1, 1, 3, 64'h0000_FFFF_FFFF_FFFF, "R2");
    // R3 wide write beyond width, counter kept
    req(1, 1, 2, 64'hFFFF_FF01_2345_6789, "R3");
    req(1, 1, 2, 64'h0001_0000_0000_0000, "R3");
    req(1, 0, 2, 0, "R3");
    // R8 fixed path
    req(2, 1, 0, 64'hFFFF_FF01_2345_6789, "R8");
    req(2, 1, 2, 64'h0000_00FF_FFFF_FFFF, "R8");
    req(2, 0, 0, 0, "R8");
    // R5 index decode type and number
    req(3, 0, 32'h4000_0000, 0, "R5");
    req(3, 0, 32'h4000_0002, 0, "R5");
    req(3, 0, 2, 0, "R5");
    req(3, 0, 3, 0, "R5");
    // R6 fast reads
    req(3, 0, 32'h8000_0001, 0, "R6");
    req(3, 0, 32'h8000_0003, 0, "R6");
    req(3, 0, 32'hC000_0002, 0, "R6");
    // R7 out-of-range indices and numbers
    req(3, 0, 64, 0, "R7");
    req(3, 0, NG, 0, "R7");
    req(3, 0, 32'h4000_0000 | NF, 0, "R7");
    req(3, 0, 32'hC000_0000 | NF, 0, "R7");
    req(0, 1, NG, 64'h1234, "R7");
    req(2, 1, NF, 64'h1234, "R7");
    req(1, 0, NG, 0, "R7");
    // R11 write on index path
    req(3, 1, 0, 64'h5555, "R11");
    req(3, 0, 0, 0, "R11");
    // R9 back-to-back fault then good read, pulse ends
    req(3, 0, 64, 0, "R9");
    req(3, 0, 32'h4000_0001, 0, "R9");
    idle_check();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule